// File: doc/BRIEF.md
# Bus Transfer Modifier with Link

This block sits on a 16-bit register-transfer bus, between the value read from the selected source and the register that receives it. A 4-bit operator tells it what to do with the value on the way. The operator can invert every bit of the value, then pass it through, add one to it, or rotate it by one place through a link bit. The block keeps two status flags: a carry flag, set by the increment, and the link flag, used by the rotates. Both change only on the clock edge where the transfer strobe is high.

The modified value appears on a registered output one cycle after the strobe. It comes with a valid pulse and the destination code, so the destination decode can write the target register. A display register watches the transfer: when the destination code equals a 6-bit selector input, it captures the same value. Decoding of the source and destination is done elsewhere.

Operator encoding: bit 3 inverts the value, bit 2 is spare, and bits 1:0 select the function. The function codes are 00 pass, 01 add one, 10 rotate left and 11 rotate right.

Top module: `bus_xfer_mod`

## Requirements
- R1: After a synchronous reset, `out_data`, `out_valid`, `out_dst`, `carry_flag`, `link_flag` and `disp_data` are all zero.
- R2: When operator bit 3 is 1, the source value is bit-inverted before the selected function acts on it. When bit 3 is 0, the source value is used as is.
- R3: With function 00 (pass), the delivered value equals the operand, and the carry and link flags keep their values.
- R4: With function 01 (add one), the delivered value is the low 16 bits of operand+1. `carry_flag` becomes 1 exactly when the operand is 0xFFFF and becomes 0 otherwise. The link flag keeps its value.
- R5: With function 10 (rotate left), the delivered value is {operand[14:0], old link} and the link takes operand[15]. The carry flag keeps its value.
- R6: With function 11 (rotate right), the delivered value is {old link, operand[15:1]} and the link takes operand[0]. The carry flag keeps its value.
- R7: On a strobe whose `dst_sel` equals `disp_sel`, `disp_data` captures the delivered value in the same edge as `out_data`. On any other strobe, `disp_data` keeps its value.
- R8: In a cycle without a strobe, `carry_flag`, `link_flag` and `disp_data` keep their values, and `out_valid` is 0 after the next edge.
- R9: Operator bit 2 has no effect on the delivered value or on the flags.
- R10: `out_valid` is 1 and `out_dst` equals `dst_sel` on the edge after a strobe. Both are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer strobe |
| xfer_op | input | 4 | Operator: bit 3 inverts, bit 2 spare, bits 1:0 select the function |
| src_data | input | 16 | Value read from the source |
| dst_sel | input | 6 | Destination code of this transfer |
| disp_sel | input | 6 | Destination code that the display register watches |
| out_data | output | 16 | Modified value, registered |
| out_valid | output | 1 | One-cycle pulse marking `out_data` |
| out_dst | output | 6 | Destination code aligned with `out_data` |
| carry_flag | output | 1 | Carry out of the add-one function |
| link_flag | output | 1 | Link bit used by the rotates |
| disp_data | output | 16 | Display register |

## Verification
The assertions assume that `xfer_valid`, `xfer_op`, `src_data`, `dst_sel` and `disp_sel` are known, not X, on every clock edge after reset. They also assume that the flag checks use the operand formed from the inputs present at the strobing edge. The bench keeps to these assumptions. It changes every input only on the falling edge and drives each input to a defined value from time zero. It holds `disp_sel` steady across each strobe. Every operator value is drawn from the 16 legal codes, so each assertion sees only defined operands.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    FN_PASS = 2'b00,
    FN_INC  = 2'b01,
    FN_ROTL = 2'b10,
    FN_ROTR = 2'b11
  } xfer_fn_e;

  typedef struct packed {
    logic     invert;
    logic     spare;
    xfer_fn_e fn;
  } xfer_op_t;
endpackage

// File: rtl/xfer_alu.sv
module xfer_alu
  import xfer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic              invert,
  input  xfer_fn_e          fn,
  input  logic              link_in,
  output logic [DATA_W-1:0] res,
  output logic              carry_we,
  output logic              carry_nx,
  output logic              link_we,
  output logic              link_nx
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] operand;
  logic [DATA_W:0]   sum;

  assign operand = invert ? ~src : src;
  assign sum     = {1'b0, operand} + {{DATA_W{1'b0}}, 1'b1};

  always_comb begin
    res      = operand;
    carry_we = 1'b0;
    carry_nx = 1'b0;
    link_we  = 1'b0;
    link_nx  = 1'b0;
    case (fn)
      FN_PASS: res = operand;
      FN_INC: begin
        res      = sum[MSB:0];
        carry_we = 1'b1;
        carry_nx = sum[DATA_W];
      end
      FN_ROTL: begin
        res     = {operand[MSB-1:0], link_in};
        link_we = 1'b1;
        link_nx = operand[MSB];
      end
      FN_ROTR: begin
        res     = {link_in, operand[MSB:1]};
        link_we = 1'b1;
        link_nx = operand[0];
      end
      default: res = operand;
    endcase
  end
endmodule

// File: rtl/xfer_flags.sv
module xfer_flags (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic carry_we,
  input  logic carry_nx,
  input  logic link_we,
  input  logic link_nx,
  output logic carry_q,
  output logic link_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      link_q  <= 1'b0;
    end else if (valid) begin
      if (carry_we) carry_q <= carry_nx;
      if (link_we)  link_q  <= link_nx;
    end
  end

  assert_flags_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(carry_q) && $stable(link_q)));
endmodule

// File: rtl/xfer_disp.sv
module xfer_disp #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [SEL_W-1:0]  dst,
  input  logic [SEL_W-1:0]  watch,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] disp_q
);
  logic hit;
  assign hit = valid && (dst == watch);

  always_ff @(posedge clk) begin
    if (rst)      disp_q <= '0;
    else if (hit) disp_q <= data;
  end

  assert_disp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && (dst != watch)) |=> $stable(disp_q));
  assert_disp_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(disp_q));
endmodule

// File: rtl/bus_xfer_mod.sv
module bus_xfer_mod
  import xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_valid,
  input  logic [3:0]        xfer_op,
  input  logic [DATA_W-1:0] src_data,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic [SEL_W-1:0]  disp_sel,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [SEL_W-1:0]  out_dst,
  output logic              carry_flag,
  output logic              link_flag,
  output logic [DATA_W-1:0] disp_data
);
  localparam int MSB = DATA_W - 1;

  xfer_op_t          op_s;
  logic              spare_unused;
  logic [DATA_W-1:0] alu_res;
  logic              c_we, c_nx, l_we, l_nx;

  assign op_s         = xfer_op_t'(xfer_op);
  assign spare_unused = op_s.spare;

  xfer_alu #(.DATA_W(DATA_W)) u_alu (
    .src      (src_data),
    .invert   (op_s.invert),
    .fn       (op_s.fn),
    .link_in  (link_flag),
    .res      (alu_res),
    .carry_we (c_we),
    .carry_nx (c_nx),
    .link_we  (l_we),
    .link_nx  (l_nx)
  );

  xfer_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .valid    (xfer_valid),
    .carry_we (c_we),
    .carry_nx (c_nx),
    .link_we  (l_we),
    .link_nx  (l_nx),
    .carry_q  (carry_flag),
    .link_q   (link_flag)
  );

  xfer_disp #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_disp (
    .clk    (clk),
    .rst    (rst),
    .valid  (xfer_valid),
    .dst    (dst_sel),
    .watch  (disp_sel),
    .data   (alu_res),
    .disp_q (disp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_dst   <= '0;
    end else begin
      out_valid <= xfer_valid;
      if (xfer_valid) begin
        out_data <= alu_res;
        out_dst  <= dst_sel;
      end
    end
  end

  assert_pass_keeps_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && op_s.fn == FN_PASS) |=> ($stable(carry_flag) && $stable(link_flag)));

  assert_inc_carry_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && op_s.fn == FN_INC) |=>
      (carry_flag == ($past(op_s.invert ? ~src_data : src_data) == {DATA_W{1'b1}})
       && $stable(link_flag)));

  assert_rotl_link_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && op_s.fn == FN_ROTL) |=>
      (link_flag == $past(op_s.invert ? ~src_data[MSB] : src_data[MSB]) && $stable(carry_flag)));

  assert_rotr_link_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && op_s.fn == FN_ROTR) |=>
      (link_flag == $past(op_s.invert ? ~src_data[0] : src_data[0]) && $stable(carry_flag)));

  assert_disp_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && dst_sel == disp_sel) |=> (disp_data == out_data));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |=> (out_valid && out_dst == $past(dst_sel)));

  assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !xfer_valid |=> !out_valid);
endmodule

// File: tb/tb_bus_xfer_mod.sv
`timescale 1ns/1ps
module tb_bus_xfer_mod;
  localparam int DW = 16;
  localparam int SW = 6;
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 16'h1234}, {4'h1, 16'hFFFF}, {4'h1, 16'h0010}, {4'h2, 16'h8001},
    {4'h2, 16'h0000}, {4'h3, 16'h0001}, {4'h3, 16'h0000}, {4'h8, 16'h1234},
    {4'h9, 16'h0000}, {4'h9, 16'hFFFF}, {4'hA, 16'h7FFF}, {4'hB, 16'hFFFE},
    {4'h4, 16'h5555}, {4'h5, 16'hFFFF}, {4'hE, 16'h00FF}, {4'hF, 16'hAAAA}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_valid = 1'b0;
  logic [3:0] xfer_op = 4'h0;
  logic [DW-1:0] src_data = '0;
  logic [SW-1:0] dst_sel = '0;
  logic [SW-1:0] disp_sel = 6'h2A;
  logic [DW-1:0] out_data, disp_data;
  logic out_valid, carry_flag, link_flag;
  logic [SW-1:0] out_dst;

  int checks = 0;
  int errors = 0;
  logic m_carry = 1'b0, m_link = 1'b0;
  logic [DW-1:0] m_disp = '0, m_res;

  always #2 clk = ~clk;

  bus_xfer_mod #(.DATA_W(DW), .SEL_W(SW)) dut (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_op(xfer_op),
    .src_data(src_data), .dst_sel(dst_sel), .disp_sel(disp_sel),
    .out_data(out_data), .out_valid(out_valid), .out_dst(out_dst),
    .carry_flag(carry_flag), .link_flag(link_flag), .disp_data(disp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from R2..R7 and R9
  task automatic model(input logic [3:0] op, input logic [DW-1:0] s, input logic [SW-1:0] d);
    logic [DW-1:0] v;
    logic [DW:0] sm;
    v = op[3] ? ~s : s;
    case (op[1:0])
      2'b00: m_res = v;
      2'b01: begin sm = {1'b0, v} + 17'd1; m_res = sm[DW-1:0]; m_carry = sm[DW]; end
      2'b10: begin m_res = {v[DW-2:0], m_link}; m_link = v[DW-1]; end
      default: begin m_res = {m_link, v[DW-1:1]}; m_link = v[0]; end
    endcase
    if (d == disp_sel) m_disp = m_res;
  endtask

  task automatic xfer(input logic [3:0] op, input logic [DW-1:0] s, input logic [SW-1:0] d,
                      input string tag);
    @(negedge clk);
    xfer_op = op; src_data = s; dst_sel = d; xfer_valid = 1'b1;
    model(op, s, d);
    @(negedge clk);
    xfer_valid = 1'b0;
    check({tag, " data"}, 32'(out_data), 32'(m_res));
    check({tag, " carry"}, 32'(carry_flag), 32'(m_carry));
    check({tag, " link"}, 32'(link_flag), 32'(m_link));
    check("R7 display", 32'(disp_data), 32'(m_disp));
    check("R10 valid", 32'(out_valid), 32'd1);
    check("R10 dst", 32'(out_dst), 32'(d));
  endtask

  function automatic string fn_tag(input logic [3:0] op);
    case (op[1:0])
      2'b00: return op[3] ? "R2 R3 pass" : "R3 pass";
      2'b01: return op[3] ? "R2 R4 inc" : "R4 inc";
      2'b10: return op[3] ? "R2 R5 rotl" : "R5 rotl";
      default: return op[3] ? "R2 R6 rotr" : "R6 rotr";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] pat [5];
    logic [15:0] c0, l0, d0;
    pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'h8000; pat[3] = 16'h0001; pat[4] = 16'hA5A5;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 data", 32'(out_data), 32'd0);
    check("R1 valid", 32'(out_valid), 32'd0);
    check("R1 dst", 32'(out_dst), 32'd0);
    check("R1 carry", 32'(carry_flag), 32'd0);
    check("R1 link", 32'(link_flag), 32'd0);
    check("R1 display", 32'(disp_data), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][19:16], VEC[i][15:0], (i % 3 == 0) ? disp_sel : 6'(i),
           VEC[i][18] ? {"R9 ", fn_tag(VEC[i][19:16])} : fn_tag(VEC[i][19:16]));
    end

    // R8 idle cycle: nothing moves
    c0 = 16'(carry_flag); l0 = 16'(link_flag); d0 = disp_data;
    @(negedge clk);
    src_data = 16'hFFFF; xfer_op = 4'h1; dst_sel = disp_sel;
    @(negedge clk);
    check("R8 valid low", 32'(out_valid), 32'd0);
    check("R8 carry", 32'(carry_flag), 32'(c0));
    check("R8 link", 32'(link_flag), 32'(l0));
    check("R8 display", 32'(disp_data), 32'(d0));

    // R7 new selector: only matching destination captures
    disp_sel = 6'h05;
    xfer(4'h0, 16'hBEEF, 6'h2A, "R7 old sel");
    xfer(4'h0, 16'hCAFE, 6'h05, "R7 new sel");

    // All operator codes against several operands
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 5; k++)
        xfer(4'(op), pat[k], 6'(op + k), op[2] ? {"R9 ", fn_tag(4'(op))} : fn_tag(4'(op)));

    // R4 carry boundary with link held at 1
    xfer(4'h2, 16'h8000, 6'h01, "R5 rotl");
    xfer(4'h1, 16'hFFFF, 6'h01, "R4 inc wrap");
    xfer(4'h1, 16'hFFFE, 6'h01, "R4 inc no carry");

    // R1 reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_carry = 1'b0; m_link = 1'b0; m_disp = '0;
    check("R1 carry after reset", 32'(carry_flag), 32'd0);
    check("R1 display after reset", 32'(disp_data), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule